// File: doc/BRIEF.md
# Down-Counting Timer Unit with PWM Output

This block is a single timer unit that counts down. A restart command loads it from a programmable cycle value. After that the count drops by one on each count tick. A tick comes from one of three places: a local prescaler that divides the clock by 1, 2, 4 or 16; an external cascade tick from a neighbouring unit; or a software event strobe. The counting mode decides what happens at zero. The unit can stop there, reload itself from the cycle value, or wrap around and keep counting down from all ones.

Two outputs follow the count. A PWM output rises when the count reaches a programmed compare value and falls when the count reaches zero. An interrupt fires at every zero event. Its width is programmable: either a sticky level that stays until it is cleared, or a pulse of 2, 4 or 8 clock cycles. Its polarity is also programmable. A pause input freezes counting. The readable count is either the live value or a snapshot taken on request. A one-cycle zero tick output lets a second unit be chained onto this one.

Top module: `pwm_down_timer`

## Requirements
- R1: After reset the count reads 0 and PWM, zero tick and the interrupt are inactive. Nothing counts until the first restart command.
- R2: A restart command loads the count from the cycle value. Each count tick then lowers the count by one.
- R3: Prescale code 0, 1, 2 or 3 gives one decrement every 1, 2, 4 or 16 clocks, counted from the restart edge. The first decrement lands exactly one divide period after that edge.
- R4: Mode code 0 (single shot) stops at 0 and holds there.
- R5: Mode code 1 (auto-reload) loads the cycle value on the first tick after the count reaches 0.
- R6: Mode code 2 (free running) wraps from 0 to all ones and keeps counting down.
- R7: Mode code 3 (event) decrements once for each cycle in which the event strobe is high. Mode codes 4 to 7 never change the count.
- R8: The PWM output goes high on the edge where the count becomes the nonzero compare value, and low on the edge where the count becomes 0. It is never high while the count is 0.
- R9: Each transition of the count to 0 raises the zero tick and the interrupt on the same edge. Width code 0 holds the interrupt until a clear strobe. Codes 1, 2 and 3 give pulses of 2, 4 and 8 clocks.
- R10: Polarity 0 makes the interrupt output active high. Polarity 1 makes it active low, so it idles high.
- R11: While pause is high the count and the prescaler hold. Counting resumes from the held value when pause drops.
- R12: With read-select 1 the read port shows the live count. With read-select 0 it shows the count captured by the most recent snapshot request.
- R13: With clock-select 1, modes 0 to 2 count only on cascade tick pulses and ignore the prescaler. The zero tick lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 3 | Counting mode (0 single, 1 reload, 2 free, 3 event, 4-7 idle) |
| prescaleSel | input | 2 | Local divide code (1, 2, 4, 16) |
| clkSel | input | 1 | 1 = count on cascadeTick, 0 = local prescaler |
| pauseIn | input | 1 | Freeze counting while high |
| restartIn | input | 1 | Reload strobe |
| eventIn | input | 1 | Event-mode decrement strobe |
| cascadeTick | input | 1 | Tick from an upstream unit |
| snapReq | input | 1 | Capture the count into the snapshot |
| readSel | input | 1 | 1 = live count, 0 = snapshot |
| cycleValue | input | CNT_W | Reload value |
| pwmCompare | input | CNT_W | PWM set point |
| intWidth | input | 2 | Interrupt width code |
| intPolarity | input | 1 | Interrupt polarity |
| intClear | input | 1 | Clears a sticky interrupt |
| countRead | output | CNT_W | Readable count |
| pwmOut | output | 1 | PWM output |
| irqOut | output | 1 | Interrupt output |
| zeroTick | output | 1 | One-cycle pulse at each zero event |

## Verification
Each input strobe is sampled on one edge, and its effect shows up on the port one register later. A restart at edge E0 puts the cycle value on the count right after E0. Decrement k is visible after edge E0 + k*divide. Zero tick, the interrupt and the PWM change on the same edge as the count they depend on. A snapshot shows the value the count held during the request cycle. The bench drives inputs one time unit after a rising edge and samples one time unit after the next rising edge. Its expected values are closed-form functions of the number of edges since the restart.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  typedef enum logic [2:0] {
    MODE_SINGLE = 3'd0,
    MODE_RELOAD = 3'd1,
    MODE_FREE   = 3'd2,
    MODE_EVENT  = 3'd3
  } timerMode_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic loadCycle;
    logic decrement;
    logic rearm;
    logic snapshot;
  } dpStrobes_t;
endpackage

// File: rtl/pwm_timer_ctrl.sv
module pwm_timer_ctrl
  import pwm_timer_pkg::*;
#(
  parameter int PRE_W = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] modeSel,
  input  logic [1:0] prescaleSel,
  input  logic       clkSel,
  input  logic       pauseIn,
  input  logic       restartIn,
  input  logic       eventIn,
  input  logic       cascadeTick,
  input  logic       snapReq,
  input  logic [1:0] intWidth,
  input  logic       intPolarity,
  input  logic       intClear,
  input  logic       countIsZero,
  input  logic       countIsOne,
  output dpStrobes_t strobes,
  output logic       irqOut,
  output logic       zeroTick
);
  localparam int PULSE_W = 4;

  logic [PRE_W-1:0]   preCnt;
  logic [PRE_W-1:0]   preMask;
  logic [PULSE_W-1:0] pulseCnt;
  logic [PULSE_W-1:0] pulseLen;
  logic running, localTick, rawTick, tick, zeroEvent, irqLevel, irqActive;
  logic modeValid, stopsAtZero;

  always_comb begin
    unique case (prescaleSel)
      2'd0:    preMask = PRE_W'(0);
      2'd1:    preMask = PRE_W'(1);
      2'd2:    preMask = PRE_W'(3);
      default: preMask = PRE_W'(15);
    endcase
    unique case (intWidth)
      2'd1:    pulseLen = PULSE_W'(2);
      2'd2:    pulseLen = PULSE_W'(4);
      default: pulseLen = PULSE_W'(8);
    endcase
  end

  assign localTick   = ((preCnt & preMask) == preMask);
  assign modeValid   = (modeSel <= 3'd3);
  assign stopsAtZero = (modeSel == MODE_SINGLE) || (modeSel == MODE_EVENT);
  assign rawTick     = (modeSel == MODE_EVENT) ? eventIn
                     : (clkSel ? cascadeTick : localTick);
  assign tick        = running && !pauseIn && modeValid && rawTick;
  assign zeroEvent   = !restartIn && tick && countIsOne;

  always_comb begin
    strobes          = '0;
    strobes.snapshot = snapReq;
    if (restartIn) begin
      strobes.loadCycle = 1'b1;
      strobes.rearm     = 1'b1;
    end else if (tick) begin
      if (!countIsZero)                 strobes.decrement = 1'b1;
      else if (modeSel == MODE_RELOAD)  strobes.loadCycle = 1'b1;
      else if (modeSel == MODE_FREE)    strobes.decrement = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt   <= '0;
      running  <= 1'b0;
      zeroTick <= 1'b0;
      irqLevel <= 1'b0;
      pulseCnt <= '0;
    end else begin
      if (restartIn)     preCnt <= '0;
      else if (!pauseIn) preCnt <= preCnt + 1'b1;

      if (restartIn)                     running <= 1'b1;
      else if (zeroEvent && stopsAtZero) running <= 1'b0;

      zeroTick <= zeroEvent;

      if (zeroEvent && intWidth == 2'd0) irqLevel <= 1'b1;
      else if (intClear)                 irqLevel <= 1'b0;

      if (zeroEvent && intWidth != 2'd0) pulseCnt <= pulseLen;
      else if (pulseCnt != '0)           pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign irqActive = (intWidth == 2'd0) ? irqLevel : (pulseCnt != '0);
  assign irqOut    = irqActive ^ intPolarity;

  // R9: a zero event raises the interrupt and the zero tick on the next edge
  a_r9_irq_on_zero: assert property (@(posedge clk) disable iff (!rstN)
    zeroEvent |=> (zeroTick && irqActive));
  // R13: the zero tick never lasts two cycles
  a_r13_tick_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    zeroTick |=> !zeroTick);
endmodule

// File: rtl/pwm_timer_datapath.sv
module pwm_timer_datapath
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobes_t       strobes,
  input  logic [CNT_W-1:0] cycleValue,
  input  logic [CNT_W-1:0] pwmCompare,
  input  logic             readSel,
  output logic [CNT_W-1:0] countLive,
  output logic [CNT_W-1:0] countRead,
  output logic             countIsZero,
  output logic             countIsOne,
  output logic             pwmOut
);
  logic [CNT_W-1:0] count, snapReg, nextCount;
  logic             compareHit;

  assign nextCount  = strobes.loadCycle ? cycleValue : (count - 1'b1);
  assign compareHit = (nextCount == pwmCompare) && (nextCount != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      snapReg <= '0;
      pwmOut  <= 1'b0;
    end else begin
      if (strobes.snapshot) snapReg <= count;
      if (strobes.loadCycle || strobes.decrement) begin
        count <= nextCount;
        if (strobes.rearm)        pwmOut <= compareHit;
        else if (nextCount == '0) pwmOut <= 1'b0;
        else if (compareHit)      pwmOut <= 1'b1;
      end
    end
  end

  assign countLive   = count;
  assign countRead   = readSel ? count : snapReg;
  assign countIsZero = (count == '0);
  assign countIsOne  = (count == CNT_W'(1));

  // R8: the PWM output is low whenever the count sits at zero
  a_r8_pwm_low_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    countIsZero |-> !pwmOut);
endmodule

// File: rtl/pwm_down_timer.sv
module pwm_down_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       modeSel,
  input  logic [1:0]       prescaleSel,
  input  logic             clkSel,
  input  logic             pauseIn,
  input  logic             restartIn,
  input  logic             eventIn,
  input  logic             cascadeTick,
  input  logic             snapReq,
  input  logic             readSel,
  input  logic [CNT_W-1:0] cycleValue,
  input  logic [CNT_W-1:0] pwmCompare,
  input  logic [1:0]       intWidth,
  input  logic             intPolarity,
  input  logic             intClear,
  output logic [CNT_W-1:0] countRead,
  output logic             pwmOut,
  output logic             irqOut,
  output logic             zeroTick
);
  dpStrobes_t       strobes;
  logic [CNT_W-1:0] countLive;
  logic             countIsZero, countIsOne;

  pwm_timer_ctrl #(.PRE_W(4)) uCtrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .prescaleSel(prescaleSel),
    .clkSel(clkSel), .pauseIn(pauseIn), .restartIn(restartIn),
    .eventIn(eventIn), .cascadeTick(cascadeTick), .snapReq(snapReq),
    .intWidth(intWidth), .intPolarity(intPolarity), .intClear(intClear),
    .countIsZero(countIsZero), .countIsOne(countIsOne),
    .strobes(strobes), .irqOut(irqOut), .zeroTick(zeroTick)
  );

  pwm_timer_datapath #(.CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cycleValue(cycleValue),
    .pwmCompare(pwmCompare), .readSel(readSel), .countLive(countLive),
    .countRead(countRead), .countIsZero(countIsZero),
    .countIsOne(countIsOne), .pwmOut(pwmOut)
  );

  // R11: a pause without restart keeps the count where it is
  a_r11_pause_holds: assert property (@(posedge clk) disable iff (!rstN)
    (pauseIn && !restartIn) |=> $stable(countLive));
  // R4: single-shot mode stays at zero
  a_r4_single_stops: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_SINGLE && countLive == '0 && !restartIn) |=> (countLive == '0));
  // R7: event mode moves only on an event strobe
  a_r7_event_only: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_EVENT && !eventIn && !restartIn) |=> $stable(countLive));
endmodule

// File: tb/pwm_down_timer_test.sv
module pwm_down_timer_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic [2:0] modeSel = 3'd0;
  logic [1:0] prescaleSel = 2'd0, intWidth = 2'd1;
  logic clkSel = 0, pauseIn = 0, restartIn = 0, eventIn = 0, cascadeTick = 0;
  logic snapReq = 0, readSel = 1, intPolarity = 0, intClear = 0;
  logic [31:0] cycleValue = '0, pwmCompare = '0;
  logic [31:0] countRead;
  logic pwmOut, irqOut, zeroTick;
  int nCompared = 0, nMismatched = 0;

  pwm_down_timer #(.CNT_W(32)) uut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .prescaleSel(prescaleSel),
    .clkSel(clkSel), .pauseIn(pauseIn), .restartIn(restartIn), .eventIn(eventIn),
    .cascadeTick(cascadeTick), .snapReq(snapReq), .readSel(readSel),
    .cycleValue(cycleValue), .pwmCompare(pwmCompare), .intWidth(intWidth),
    .intPolarity(intPolarity), .intClear(intClear), .countRead(countRead),
    .pwmOut(pwmOut), .irqOut(irqOut), .zeroTick(zeroTick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCompared++;
    if (act !== exp) begin
      nMismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic restart();
    restartIn = 1; step(); restartIn = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nMismatched++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

  initial begin
    step(); step(); rstN = 1; step();
    // R1: reset state and no counting before restart
    cycleValue = 32'd5;
    for (int i = 0; i < 4; i++) begin
      step();
      check("R1 count", countRead, 0);
      check("R1 pwm", {31'd0, pwmOut}, 0);
      check("R1 irq", {31'd0, irqOut}, 0);
      check("R1 tick", {31'd0, zeroTick}, 0);
    end

    // R2 R3 R4 R9: sweep prescale and cycle value in single mode, 2-cycle pulse
    for (int ps = 0; ps < 4; ps++) begin
      for (int cyc = 1; cyc <= 3; cyc++) begin
        int div, z;
        div = (ps == 0) ? 1 : (ps == 1) ? 2 : (ps == 2) ? 4 : 16;
        z = cyc * div;
        modeSel = 3'd0; prescaleSel = 2'(ps); intWidth = 2'd1;
        cycleValue = 32'(cyc); pwmCompare = 32'd0;
        restart();
        check("R2 load", countRead, 32'(cyc));
        for (int t = 1; t <= z + 4; t++) begin
          step();
          check("R3 R4 count", countRead, (t / div >= cyc) ? 32'd0 : 32'(cyc - t / div));
          check("R9 tick", {31'd0, zeroTick}, (t == z) ? 32'd1 : 32'd0);
          check("R9 pulse", {31'd0, irqOut}, (t == z || t == z + 1) ? 32'd1 : 32'd0);
        end
      end
    end

    // R5: auto-reload, period cyc+1
    modeSel = 3'd1; prescaleSel = 2'd0; cycleValue = 32'd3;
    restart();
    for (int t = 1; t <= 12; t++) begin
      step();
      check("R5 reload", countRead, 32'(3 - (t % 4)));
    end

    // R6: free running wrap
    modeSel = 3'd2; cycleValue = 32'd2;
    restart();
    for (int t = 1; t <= 6; t++) begin
      step();
      check("R6 wrap", countRead, 32'd2 - 32'(t));
    end

    // R8: PWM set at compare, clear at zero
    modeSel = 3'd0; cycleValue = 32'd6; pwmCompare = 32'd3;
    restart();
    check("R8 pwm after load", {31'd0, pwmOut}, 0);
    for (int t = 1; t <= 9; t++) begin
      step();
      check("R8 pwm", {31'd0, pwmOut}, (t >= 3 && t < 6) ? 32'd1 : 32'd0);
    end
    pwmCompare = 32'd6;
    restart();
    check("R8 pwm compare equals load", {31'd0, pwmOut}, 1);
    pwmCompare = 32'd0;

    // R7: event mode and reserved modes
    modeSel = 3'd3; cycleValue = 32'd5;
    restart();
    step(); step(); step();
    check("R7 event idle", countRead, 5);
    eventIn = 1; step(); eventIn = 0;
    check("R7 event dec", countRead, 4);
    eventIn = 1; step(); step(); eventIn = 0;
    check("R7 two events", countRead, 2);
    modeSel = 3'd5;
    restart();
    for (int t = 0; t < 4; t++) step();
    check("R7 reserved mode", countRead, 5);

    // R9: sticky interrupt
    modeSel = 3'd0; intWidth = 2'd0; cycleValue = 32'd2;
    restart();
    for (int t = 1; t <= 10; t++) begin
      step();
      check("R9 sticky", {31'd0, irqOut}, (t >= 2) ? 32'd1 : 32'd0);
    end
    intClear = 1; step(); intClear = 0;
    check("R9 cleared", {31'd0, irqOut}, 0);

    // R10: active-low interrupt, 4-cycle pulse
    intPolarity = 1; intWidth = 2'd2; cycleValue = 32'd1;
    #1 check("R10 idle high", {31'd0, irqOut}, 1);
    restart();
    for (int t = 1; t <= 6; t++) begin
      step();
      check("R10 low pulse", {31'd0, irqOut}, (t >= 1 && t <= 4) ? 32'd0 : 32'd1);
    end
    intPolarity = 0; intWidth = 2'd3;
    cycleValue = 32'd2;
    restart();
    for (int t = 1; t <= 11; t++) begin
      step();
      check("R9 eight pulse", {31'd0, irqOut}, (t >= 2 && t <= 9) ? 32'd1 : 32'd0);
    end

    // R11: pause
    modeSel = 3'd1; cycleValue = 32'd10;
    restart();
    step(); step(); step();
    pauseIn = 1;
    for (int t = 0; t < 5; t++) begin
      step();
      check("R11 paused", countRead, 7);
    end
    pauseIn = 0; step();
    check("R11 resume", countRead, 6);

    // R12: snapshot vs live
    modeSel = 3'd0; cycleValue = 32'd20;
    restart();
    for (int t = 0; t < 4; t++) step();
    snapReq = 1; step(); snapReq = 0;
    readSel = 0;
    step(); step(); step();
    #1 check("R12 snapshot", countRead, 16);
    readSel = 1;
    #1 check("R12 live", countRead, 12);

    // R13: cascade ticks
    clkSel = 1; prescaleSel = 2'd3; cycleValue = 32'd3; intWidth = 2'd1;
    restart();
    for (int t = 0; t < 5; t++) step();
    check("R13 no cascade", countRead, 3);
    cascadeTick = 1; step(); cascadeTick = 0; step();
    check("R13 one cascade", countRead, 2);
    cascadeTick = 1; step(); step();
    check("R13 zero", countRead, 0);
    check("R13 tick high", {31'd0, zeroTick}, 1);
    cascadeTick = 0; step();
    check("R13 tick drops", {31'd0, zeroTick}, 0);
    clkSel = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end
endmodule